// File: doc/BRIEF.md
# SPI Command Sequencer

This block runs a single-lane SPI master from a queue of 32-bit command entries. Software pushes entries into a four-deep command queue, outbound data words into an eight-word transmit queue, and pops inbound words from an eight-word receive queue. It does not drive the bus byte by byte. Each entry describes its own step. It can set or clear the chip select and then wait, shift out one immediate byte, or move a counted run of data bytes. The count is either the immediate value itself or two raised to that value.

A sequencer state machine walks each entry through the states IDLE, DECODE, DWELL, NEXT, SHIFT and IMM:
- IDLE to DECODE: an entry is popped while the enable input is high.
- DECODE to IDLE: the entry does not select the lower bus.
- DECODE to NEXT: the entry is a counted data entry.
- DECODE to IMM: the entry is an immediate byte entry.
- DECODE to DWELL: the entry is a chip-select/wait entry.
- DWELL to IDLE: the wait counter reaches zero.
- NEXT to SHIFT: a byte starts.
- NEXT stays in NEXT: a new transmit word is needed and the transmit queue is empty.
- NEXT to IDLE: the byte count is used up.
- SHIFT to NEXT and IMM to IDLE: the byte engine reports that its byte is done.

A divider and clock polarity and phase inputs shape the serial clock.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: An entry with bit 14 (lower bus) set drives spi_cs_n to the inverse of its bit 12. An entry with bit 14 clear is consumed and leaves every pin unchanged. With bits 8 and 16 clear, the entry then waits imm+1 cycles, where imm is bits [7:0].
- R2: An entry with bit 8 clear and bit 16 (transmit) set shifts out imm[7:0] as one byte and writes nothing to the receive queue.
- R3: An entry with bit 8 (data) set and bit 9 clear moves imm bytes. With bit 9 (exponent) set it moves 2^imm[3:0] bytes. A count of zero moves none.
- R4: With bit 16 set, data bytes come from transmit words, least-significant byte first. A new word is taken at byte lane 0. The unused bytes of the last word of an entry are discarded.
- R5: With bit 17 (receive) set, inbound bytes are packed least-significant byte first. Each full word is pushed. A partial word is pushed at entry end with zero upper bytes. With bit 17 clear, nothing is pushed.
- R6: The serial clock period is 2<<cfg_div clock cycles, where cfg_div is 3 bits.
- R7: spi_sclk idles at cfg_cpol. Bytes go out MSB first. With cfg_cpha=0, spi_miso is sampled on the leading edge; with cfg_cpha=1, it is sampled on the trailing edge.
- R8: No entry is popped while enable is low. An entry already running completes.
- R9: cmd_empty, tx_not_full and tx_full reflect their queues. rx_not_empty reflects the receive queue. After reset, cmd_empty=1, tx_not_full=1, tx_full=0 and rx_not_empty=0.
- R10: A write to a full queue is dropped and sets that queue's overflow flag. The flag stays set until reset.
- R11: A data entry with bit 16 clear shifts out 0xFF for each byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Allows new entries to start |
| cfg_div | input | 3 | Serial clock divider exponent |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sample on trailing edge when set |
| cmd_wr | input | 1 | Push a command entry |
| cmd_wdata | input | 32 | Command entry |
| tx_wr | input | 1 | Push a transmit word |
| tx_wdata | input | 32 | Transmit word |
| rx_rd | input | 1 | Pop the head receive word |
| rx_rdata | output | 32 | Head receive word |
| cmd_empty | output | 1 | Command queue empty |
| tx_not_full | output | 1 | Transmit queue has room |
| tx_full | output | 1 | Transmit queue full |
| rx_not_empty | output | 1 | Receive queue holds a word |
| cmd_ovf | output | 1 | Sticky command queue overflow |
| tx_ovf | output | 1 | Sticky transmit queue overflow |
| rx_ovf | output | 1 | Sticky receive queue overflow |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Queue flags change at the first clock edge after a push or pop. An entry pushed while enabled reaches spi_cs_n two edges after it lands in the queue: one edge to pop it and one edge to decode it. A byte takes 16 half periods of 1<<cfg_div cycles each. A received word appears at the receive queue one edge after its last byte completes. The bench drives inputs and samples outputs on falling clock edges. It waits for the command queue to drain plus a fixed margin longer than the final wait entry. It captures serial bits with its own monitor on the sampling edge that cfg_cpol and cfg_cpha select, and times the serial period between the first two such edges.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [12:0] rsvd;
        logic        stripe;
        logic        rx;
        logic        tx;
        logic        bus_hi;
        logic        bus_lo;
        logic        cs_hi;
        logic        cs_lo;
        logic [1:0]  lane_mode;
        logic        expo;
        logic        xfer;
        logic [7:0]  imm;
    } seq_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DWELL,
        ST_NEXT,
        ST_SHIFT,
        ST_IMM
    } seq_state_t;

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             wr_ok, rd_ok;

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
            if (wr && full) ovf <= 1'b1;
        end
    end

    AST_OVF_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |=> ovf); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R10
    AST_EMPTY_READ_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && empty && !wr) |=> empty); // R9

endmodule

// File: rtl/seq_spi_shift.sv
module seq_spi_shift #(
    parameter int DIV_W  = 3,
    parameter int BITS_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [BITS_N-1:0] tx_byte,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [BITS_N-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi
);
    localparam int HCNT_W = (1 << DIV_W) - 1;
    localparam int EDGES  = 2 * BITS_N;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    logic [HCNT_W-1:0] hcnt, half_m1;
    logic [EDGE_W-1:0] edge_idx;
    logic [BITS_N-1:0] tx_sr, rx_sr;
    logic              tick, sample_now, shift_now;

    assign half_m1    = (HCNT_W'(1) << div) - HCNT_W'(1);
    assign tick       = busy && (hcnt == half_m1);
    assign sample_now = (edge_idx[0] == cpha);
    assign shift_now  = !sample_now && (edge_idx != '0) && (edge_idx != LAST_EDGE);
    assign mosi       = tx_sr[BITS_N-1];
    assign rx_byte    = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            hcnt     <= '0;
            edge_idx <= '0;
            tx_sr    <= '1;
            rx_sr    <= '0;
            sclk     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                sclk <= cpol;
                hcnt <= '0;
                if (start) begin
                    busy     <= 1'b1;
                    tx_sr    <= tx_byte;
                    edge_idx <= '0;
                end
            end else if (tick) begin
                hcnt     <= '0;
                sclk     <= ~sclk;
                edge_idx <= edge_idx + 1'b1;
                if (sample_now) rx_sr <= {rx_sr[BITS_N-2:0], miso};
                if (shift_now)  tx_sr <= {tx_sr[BITS_N-2:0], 1'b1};
                if (edge_idx == LAST_EDGE) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    AST_SCLK_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sclk == cpol)); // R7
    AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sclk)); // R6
    AST_DONE_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
    import spi_seq_pkg::*;
#(
    parameter int CMD_DEPTH  = 4,
    parameter int DATA_DEPTH = 8,
    parameter int DIV_W      = 3,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              cmd_empty,
    output logic              tx_not_full,
    output logic              tx_full,
    output logic              rx_not_empty,
    output logic              cmd_ovf,
    output logic              tx_ovf,
    output logic              rx_ovf,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int EXP_W  = $clog2(CNT_W);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

    seq_state_t state, state_d;
    seq_entry_t entry_q, cmd_head;

    logic [WORD_W-1:0] cmd_rdata, tx_head, word_q, rx_acc, rx_merged, rx_push_data;
    logic [CNT_W-1:0]  remaining;
    logic [7:0]        dwell;
    logic [LANE_W-1:0] lane;
    logic              cs_n_q;
    logic              cmd_pop, tx_pop, rx_push, tx_empty, rx_empty, rx_full;
    logic              eng_start, eng_busy, eng_done;
    logic [BYTE_W-1:0] eng_byte, eng_rx;
    logic              need_word, word_wait;

    seq_fifo #(.WIDTH(WORD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_wdata), .rd(cmd_pop),
        .rdata(cmd_rdata), .empty(cmd_empty), .full(), .ovf(cmd_ovf));

    seq_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata), .rd(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full), .ovf(tx_ovf));

    seq_fifo #(.WIDTH(WORD_W), .DEPTH(DATA_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata(rx_push_data), .rd(rx_rd),
        .rdata(rx_rdata), .empty(rx_empty), .full(rx_full), .ovf(rx_ovf));

    seq_spi_shift #(.DIV_W(DIV_W), .BITS_N(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha), .div(cfg_div),
        .start(eng_start), .tx_byte(eng_byte), .miso(spi_miso), .busy(eng_busy),
        .done(eng_done), .rx_byte(eng_rx), .sclk(spi_sclk), .mosi(spi_mosi));

    assign cmd_head     = seq_entry_t'(cmd_rdata);
    assign tx_not_full  = !tx_full;
    assign rx_not_empty = !rx_empty;
    assign spi_cs_n     = cs_n_q;

    // Fields kept for the entry format but not acted on by a single-lane master.
    logic unused_fields;
    assign unused_fields = ^{entry_q.rsvd, entry_q.stripe, entry_q.bus_hi,
                             entry_q.cs_hi, entry_q.lane_mode, rx_full};

    assign need_word = entry_q.tx && (lane == '0);
    assign word_wait = need_word && tx_empty;

    always_comb begin
        rx_merged = rx_acc;
        rx_merged[lane*BYTE_W +: BYTE_W] = eng_rx;
    end

    // Next-state process.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (enable && !cmd_empty) state_d = ST_DECODE;
            ST_DECODE: begin
                if (!entry_q.bus_lo)   state_d = ST_IDLE;
                else if (entry_q.xfer) state_d = ST_NEXT;
                else if (entry_q.tx)   state_d = ST_IMM;
                else                   state_d = ST_DWELL;
            end
            ST_DWELL:  if (dwell == '0) state_d = ST_IDLE;
            ST_NEXT: begin
                if (remaining == '0) state_d = ST_IDLE;
                else if (!word_wait) state_d = ST_SHIFT;
            end
            ST_SHIFT:  if (eng_done) state_d = ST_NEXT;
            ST_IMM:    if (eng_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        cmd_pop      = 1'b0;
        tx_pop       = 1'b0;
        rx_push      = 1'b0;
        rx_push_data = rx_acc;
        eng_start    = 1'b0;
        eng_byte     = '1;
        unique case (state)
            ST_IDLE: cmd_pop = enable && !cmd_empty;
            ST_DECODE: begin
                if (entry_q.bus_lo && !entry_q.xfer && entry_q.tx) begin
                    eng_start = 1'b1;
                    eng_byte  = entry_q.imm;
                end
            end
            ST_NEXT: begin
                if (remaining == '0) begin
                    rx_push = entry_q.rx && (lane != '0);
                end else if (!word_wait) begin
                    eng_start = 1'b1;
                    tx_pop    = need_word;
                    if (entry_q.tx)
                        eng_byte = need_word ? tx_head[BYTE_W-1:0]
                                             : word_q[lane*BYTE_W +: BYTE_W];
                end
            end
            ST_SHIFT: begin
                if (eng_done && entry_q.rx && (lane == TOP_LANE)) begin
                    rx_push      = 1'b1;
                    rx_push_data = rx_merged;
                end
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q   <= '0;
            remaining <= '0;
            dwell     <= '0;
            lane      <= '0;
            word_q    <= '0;
            rx_acc    <= '0;
            cs_n_q    <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_pop) entry_q <= cmd_head;
                ST_DECODE: begin
                    if (entry_q.bus_lo) cs_n_q <= ~entry_q.cs_lo;
                    remaining <= entry_q.expo ? (CNT_W'(1) << entry_q.imm[EXP_W-1:0])
                                              : CNT_W'(entry_q.imm);
                    dwell  <= entry_q.imm;
                    lane   <= '0;
                    rx_acc <= '0;
                end
                ST_DWELL: if (dwell != '0) dwell <= dwell - 1'b1;
                ST_NEXT:  if (tx_pop) word_q <= tx_head;
                ST_SHIFT: begin
                    if (eng_done) begin
                        remaining <= remaining - 1'b1;
                        lane      <= lane + 1'b1;
                        if (entry_q.rx)
                            rx_acc <= (lane == TOP_LANE) ? '0 : rx_merged;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_HOLD_WHILE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> (state == ST_IDLE)); // R8
    AST_CS_STABLE_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |=> $stable(spi_cs_n)); // R1
    AST_START_ENGINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy); // R6
    AST_NO_RX_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT && !entry_q.rx) |=> !rx_not_empty || $stable(rx_not_empty)); // R5

endmodule

// File: tb/sim_spi_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_spi_cmd_sequencer;

    typedef struct packed {
        logic [2:0]  div;
        logic        cpol;
        logic        cpha;
        logic [7:0]  nb;
        logic [31:0] tx;
        logic [31:0] rx;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 1'b0, 8'd4, 32'h8C31F05A, 32'h8C31F05A},
        '{3'd1, 1'b0, 1'b1, 8'd3, 32'h12345678, 32'h00345678},
        '{3'd2, 1'b1, 1'b0, 8'd2, 32'hDEADBEEF, 32'h0000BEEF},
        '{3'd0, 1'b1, 1'b1, 8'd1, 32'h0F0F0FC3, 32'h000000C3},
        '{3'd3, 1'b0, 1'b0, 8'd4, 32'hA5A55A5A, 32'hA5A55A5A},
        '{3'd1, 1'b1, 1'b1, 8'd4, 32'h01800001, 32'h01800001}
    };

    localparam logic [31:0] C_CS_ON  = 32'h0000_5405;
    localparam logic [31:0] C_CS_OFF = 32'h0000_4005;
    localparam logic [31:0] C_TXRX   = 32'h0003_5500;
    localparam logic [31:0] C_TXONLY = 32'h0001_5500;
    localparam logic [31:0] C_RXONLY = 32'h0002_5500;
    localparam logic [31:0] C_EXPO   = 32'h0000_0200;
    localparam logic [31:0] C_IMM    = 32'h0001_5400;
    localparam logic [31:0] C_NOBUS  = 32'h0000_1405;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
    logic [2:0] cfg_div = 3'd0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic cmd_wr = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [31:0] cmd_wdata = '0, tx_wdata = '0;
    logic [31:0] rx_rdata;
    logic cmd_empty, tx_not_full, tx_full, rx_not_empty, cmd_ovf, tx_ovf, rx_ovf;
    logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;
    assign spi_miso = spi_mosi;

    spi_cmd_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .cmd_empty(cmd_empty), .tx_not_full(tx_not_full), .tx_full(tx_full),
        .rx_not_empty(rx_not_empty), .cmd_ovf(cmd_ovf), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    // Serial monitor: collects bits on the sampling edge chosen by the mode.
    logic [7:0] mon_bytes [64];
    logic [7:0] mon_sr;
    int mon_cnt = 0, mon_bits = 0, mon_edges = 0;
    realtime t_first, t_second;

    task automatic mon_take(input logic b);
        if (mon_edges == 0) t_first = $realtime;
        else if (mon_edges == 1) t_second = $realtime;
        mon_edges++;
        mon_sr = {mon_sr[6:0], b};
        mon_bits++;
        if (mon_bits == 8) begin
            if (mon_cnt < 64) mon_bytes[mon_cnt] = mon_sr;
            mon_cnt++;
            mon_bits = 0;
        end
    endtask

    always @(posedge spi_sclk) if (!spi_cs_n && (cfg_cpol == cfg_cpha)) mon_take(spi_mosi);
    always @(negedge spi_sclk) if (!spi_cs_n && (cfg_cpol != cfg_cpha)) mon_take(spi_mosi);

    task automatic mon_clear();
        mon_cnt = 0; mon_bits = 0; mon_edges = 0; mon_sr = '0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [31:0] w);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic push_tx(input logic [31:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx(output logic [31:0] w);
        @(negedge clk); w = rx_rdata; rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!cmd_empty) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R9 cmd_empty after reset", 32'(cmd_empty), 32'd1);
        check("R9 tx_not_full after reset", 32'(tx_not_full), 32'd1);
        check("R9 tx_full after reset", 32'(tx_full), 32'd0);
        check("R9 rx_not_empty after reset", 32'(rx_not_empty), 32'd0);
        check("R10 overflow flags after reset", {29'd0, cmd_ovf, tx_ovf, rx_ovf}, 32'd0);
        check("R1 cs_n after reset", 32'(spi_cs_n), 32'd1);

        // Vector table: full-duplex data entries in all clock modes
        for (int v = 0; v < NVEC; v++) begin
            cfg_div = VECS[v].div; cfg_cpol = VECS[v].cpol; cfg_cpha = VECS[v].cpha;
            repeat (4) @(negedge clk);
            mon_clear();
            push_tx(VECS[v].tx);
            push_cmd(C_CS_ON);
            push_cmd(C_TXRX | 32'(VECS[v].nb));
            push_cmd(C_CS_OFF);
            wait_done();
            check("R3 byte count", 32'(mon_cnt), 32'(VECS[v].nb));
            for (int b = 0; b < 4; b++)
                if (b < int'(VECS[v].nb))
                    check("R4 R7 byte order", 32'(mon_bytes[b]), 32'(VECS[v].tx[8*b +: 8]));
            check("R6 serial period", 32'(int'((t_second - t_first) / 4.0)),
                  32'(2 << VECS[v].div));
            check("R7 sclk idle level", 32'(spi_sclk), 32'(VECS[v].cpol));
            check("R9 rx_not_empty after data", 32'(rx_not_empty), 32'd1);
            read_rx(w);
            check("R5 received word", w, VECS[v].rx);
        end

        cfg_div = 3'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;

        // Enable gating
        enable = 1'b0;
        push_cmd(C_CS_ON);
        repeat (40) @(negedge clk);
        check("R8 cs_n stays high while disabled", 32'(spi_cs_n), 32'd1);
        check("R8 entry kept while disabled", 32'(cmd_empty), 32'd0);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 cs_n asserted by entry", 32'(spi_cs_n), 32'd0);
        push_cmd(C_CS_OFF);
        wait_done();
        check("R1 cs_n released by entry", 32'(spi_cs_n), 32'd1);

        // Immediate byte
        mon_clear();
        push_cmd(C_CS_ON);
        push_cmd(C_IMM | 32'h0000_00A5);
        push_cmd(C_CS_OFF);
        wait_done();
        check("R2 immediate byte count", 32'(mon_cnt), 32'd1);
        check("R2 immediate byte value", 32'(mon_bytes[0]), 32'h0000_00A5);
        check("R2 no receive word", 32'(rx_not_empty), 32'd0);

        // Partial word discard
        mon_clear();
        push_tx(32'h44332211);
        push_tx(32'h000000EE);
        push_cmd(C_CS_ON);
        push_cmd(C_TXONLY | 32'd3);
        push_cmd(C_TXONLY | 32'd1);
        push_cmd(C_CS_OFF);
        wait_done();
        check("R4 bytes across entries", 32'(mon_cnt), 32'd4);
        check("R4 byte 0", 32'(mon_bytes[0]), 32'h11);
        check("R4 byte 2", 32'(mon_bytes[2]), 32'h33);
        check("R4 upper byte discarded", 32'(mon_bytes[3]), 32'hEE);
        check("R5 no receive without flag", 32'(rx_not_empty), 32'd0);

        // Exponent length
        mon_clear();
        push_tx(32'hCAFEF00D);
        push_tx(32'h76543210);
        push_cmd(C_CS_ON);
        push_cmd(C_TXRX | C_EXPO | 32'd3);
        push_cmd(C_CS_OFF);
        wait_done();
        check("R3 exponent byte count", 32'(mon_cnt), 32'd8);
        read_rx(w);
        check("R5 first packed word", w, 32'hCAFEF00D);
        read_rx(w);
        check("R5 second packed word", w, 32'h76543210);

        // Receive-only entry sends ones
        mon_clear();
        push_cmd(C_CS_ON);
        push_cmd(C_RXONLY | 32'd2);
        push_cmd(C_CS_OFF);
        wait_done();
        check("R11 filler byte", 32'(mon_bytes[1]), 32'hFF);
        read_rx(w);
        check("R11 R5 partial word of ones", w, 32'h0000FFFF);

        // Entry without lower bus is consumed with no effect
        push_cmd(C_NOBUS);
        wait_done();
        check("R1 skipped entry leaves cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 skipped entry consumed", 32'(cmd_empty), 32'd1);

        // Transmit queue full and overflow
        for (int k = 0; k < 8; k++) push_tx(32'h01010101 * (k + 1));
        @(negedge clk);
        check("R9 tx_full at depth", 32'(tx_full), 32'd1);
        check("R9 tx_not_full at depth", 32'(tx_not_full), 32'd0);
        check("R10 no overflow before extra write", 32'(tx_ovf), 32'd0);
        push_tx(32'hFFFF0000);
        @(negedge clk);
        check("R10 tx overflow flag", 32'(tx_ovf), 32'd1);
        mon_clear();
        push_cmd(C_CS_ON);
        push_cmd(C_TXONLY | C_EXPO | 32'd5);
        push_cmd(C_CS_OFF);
        wait_done();
        check("R3 drained byte count", 32'(mon_cnt), 32'd32);
        check("R10 dropped word not sent", 32'(mon_bytes[31]), 32'h08);
        check("R9 tx_not_full after drain", 32'(tx_not_full), 32'd1);
        check("R10 tx overflow sticky", 32'(tx_ovf), 32'd1);

        // Command queue overflow
        enable = 1'b0;
        for (int k = 0; k < 5; k++) push_cmd(C_CS_OFF);
        @(negedge clk);
        check("R10 cmd overflow flag", 32'(cmd_ovf), 32'd1);
        enable = 1'b1;
        wait_done();
        check("R9 cmd queue drains", 32'(cmd_empty), 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule